// File: doc/BRIEF.md
# Memory-Mapped BCD Real-Time Clock

This block is a calendar clock that sits at the top eight byte addresses of a byte-addressed window. A host reaches it through a simple synchronous port: one address bus, a write strobe with write data, and a combinational read-data output. The live time counters are private. They advance by one second on each single-cycle `tick_1hz` strobe, as long as the stop bit is clear. What the host reads is a separate set of shadow registers. The block refreshes the shadow registers from the counters on every tick.

The host has two control bits in the control byte. The freeze bit holds the shadow copy still, so the host can read several fields that all belong to the same second, while the live counters keep running. The load bit also holds the shadow copy still, and the host then writes new time values into it. When the host clears the load bit, the block copies the shadow time fields into the live counters in one step. All time fields are packed BCD. The counters handle month lengths, leap years, a day-of-week counter and a century flag.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the registers read as follows: control 00h, seconds 80h (stop bit set, count 00), minutes 00h, hours 00h, day 01h, date 01h, month 01h, year 00h.
- R2: The register window is the eight highest addresses, base = 2^ADDR_W − 8. The offsets from the base are: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. A read below the window returns 00h, and a write below the window changes nothing.
- R3: Seconds and minutes count in BCD from 00 to 59 and wrap. Each wrap carries into the next field. Hours count from 00 to 23 and then wrap, which carries into the date.
- R4: The date wraps back to 01 after 28 in February of a non-leap year, after 29 in February of a leap year, after 30 in months 04, 06, 09 and 11, and after 31 in all other months. A year is a leap year when its two-digit value mod 4 is 0, and 00 counts as a leap year. When the date wraps, the month advances.
- R5: The day-of-week field (day register bits 2:0) counts 1 to 7. It advances on every date change and goes from 7 back to 1.
- R6: The month wraps from 12 to 01, which advances the year. The year wraps from 99 to 00. When the year wraps and century enable (day register bit 5) is 1, the century bit (day register bit 4) toggles. When century enable is 0, the century bit keeps its value.
- R7: The stop bit is bit 7 of the seconds register. While it is 1, ticks do not advance the time. Writing 0 to it lets the next tick advance the time again.
- R8: While freeze (control bit 6) is 1, the shadow registers hold the values from the last refresh, and the live counters keep counting. After freeze is cleared, the first tick shows the live time.
- R9: While load (control bit 7) is 1, ticks do not refresh the shadow registers, and host writes to them stay in place. When a control write clears the load bit, the shadow time fields and the century bit are copied into the live counters. The next tick advances from the copied values.
- R10: A tick that arrives in the same cycle as a control write that sets freeze still completes its refresh. The frozen copy therefore shows the advanced time.
- R11: With load at 0, a host write to a time field changes only the shadow copy, and the next refresh overwrites it. Writes to the stop bit, century enable and century bit take effect in the live counters straight away.
- R12: Unused bit positions are dropped on write and read as 0. These are: minutes bit 7, hours bits 7:6, day bits 7 and 3, date bits 7:6, and month bits 7:5. Day register bit 6 (frequency test) is plain storage.
- R13: The time advances only in cycles where `tick_1hz` is 1. Without a tick, the time read back does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle strobe that advances the time by one second |
| addr | input | ADDR_W | Byte address; only the top eight addresses select the clock |
| wr_en | input | 1 | Writes `wdata` to the addressed register at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Contents of the addressed register, combinational; 00h outside the window |

## Verification
The carry chain is driven from loaded times that stop one or two seconds before each boundary: a 31-day month end, February of a non-leap year, February 28 and 29 of a leap year, February of year 00, a 30-day month end, and a 30th in a 31-day month that must not wrap. Each of these catches a different mistake in the month-length table or the mod-4 test. A year wrap is run twice, once with century enable set and once with it clear, to tell a century bit that toggles apart from one that always or never toggles. The shadow handshakes are tried as separate sequences: freeze held across several ticks, load with writes in between, a tick that lands in the same cycle as setting freeze, and direct writes with load at 0. Together these tell a shadow copy that refreshes, holds and loads correctly apart from one that tracks the counters directly.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NREG  = 8;
    localparam int OFF_W = $clog2(NREG);

    // time fields kept as packed BCD bytes
    typedef struct packed {
        logic [7:0] secs;
        logic [7:0] mins;
        logic [7:0] hrs;
        logic [2:0] dow;
        logic [7:0] date;
        logic [7:0] mon;
        logic [7:0] yr;
        logic       cent;
    } rtc_time_t;

    localparam rtc_time_t TIME_RST = '{secs: 8'h00, mins: 8'h00, hrs: 8'h00,
                                       dow: 3'd1, date: 8'h01, mon: 8'h01,
                                       yr: 8'h00, cent: 1'b0};

    typedef enum logic [OFF_W-1:0] {
        OFF_CTRL = 3'd0,
        OFF_SEC  = 3'd1,
        OFF_MIN  = 3'd2,
        OFF_HR   = 3'd3,
        OFF_DAY  = 3'd4,
        OFF_DATE = 3'd5,
        OFF_MON  = 3'd6,
        OFF_YR   = 3'd7
    } reg_off_e;

    localparam logic [7:0] MASK_SEC  = 8'h7F;
    localparam logic [7:0] MASK_MIN  = 8'h7F;
    localparam logic [7:0] MASK_HR   = 8'h3F;
    localparam logic [7:0] MASK_DATE = 8'h3F;
    localparam logic [7:0] MASK_MON  = 8'h1F;

    localparam int CTRL_LOAD_BIT   = 7;
    localparam int CTRL_FREEZE_BIT = 6;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // year mod 4 from BCD digits: (2*tens + ones) mod 4
    function automatic logic bcd_leap(input logic [7:0] y);
        logic [1:0] r;
        r = {y[4], 1'b0} + y[1:0];
        return (r == 2'd0);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_calendar_step.sv
module rtc_calendar_step
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      cent_en,
    output rtc_time_t nxt
);
    logic c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        nxt   = cur;
        c_min = (cur.secs >= 8'h59);
        c_hr  = c_min && (cur.mins >= 8'h59);
        c_day = c_hr && (cur.hrs >= 8'h23);
        c_mon = c_day && (cur.date >= month_last(cur.mon, cur.yr));
        c_yr  = c_mon && (cur.mon >= 8'h12);

        nxt.secs = c_min ? 8'h00 : bcd_inc(cur.secs);
        if (c_min) nxt.mins = c_hr ? 8'h00 : bcd_inc(cur.mins);
        if (c_hr)  nxt.hrs  = c_day ? 8'h00 : bcd_inc(cur.hrs);
        if (c_day) begin
            nxt.dow  = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
            nxt.date = c_mon ? 8'h01 : bcd_inc(cur.date);
        end
        if (c_mon) nxt.mon = c_yr ? 8'h01 : bcd_inc(cur.mon);
        if (c_yr) begin
            nxt.yr = (cur.yr >= 8'h99) ? 8'h00 : bcd_inc(cur.yr);
            if ((cur.yr >= 8'h99) && cent_en) nxt.cent = ~cur.cent;
        end
    end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      load,
    input  rtc_time_t load_val,
    input  logic      cent_wr,
    input  logic      cent_val,
    input  logic      cent_en,
    output rtc_time_t live_q,
    output rtc_time_t live_d
);
    rtc_time_t stepped;

    rtc_calendar_step u_step (
        .cur     (live_q),
        .cent_en (cent_en),
        .nxt     (stepped)
    );

    // priority: load, then direct century write, then tick advance
    always_comb begin
        live_d = live_q;
        if (load) begin
            live_d = load_val;
        end else begin
            if (adv)     live_d = stepped;
            if (cent_wr) live_d.cent = cent_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= TIME_RST;
        else        live_q <= live_d;
    end
endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
    import rtc_pkg::*;
(
    input  logic                 hit,
    input  logic [OFF_W-1:0]     off,
    input  rtc_time_t            shadow,
    input  logic [7:0]           ctrl,
    input  logic                 stop,
    input  logic                 cent_en,
    input  logic                 ftest,
    output logic [7:0]           rdata
);
    always_comb begin
        rdata = 8'h00;
        if (hit) begin
            case (off)
                OFF_CTRL: rdata = ctrl;
                OFF_SEC:  rdata = {stop, shadow.secs[6:0]};
                OFF_MIN:  rdata = shadow.mins & MASK_MIN;
                OFF_HR:   rdata = shadow.hrs & MASK_HR;
                OFF_DAY:  rdata = {1'b0, ftest, cent_en, shadow.cent, 1'b0, shadow.dow};
                OFF_DATE: rdata = shadow.date & MASK_DATE;
                OFF_MON:  rdata = shadow.mon & MASK_MON;
                default:  rdata = shadow.yr;
            endcase
        end
    end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    typedef struct packed {
        rtc_time_t  sh;
        logic [7:0] ctrl;
        logic       stop;
        logic       cent_en;
        logic       ftest;
    } host_t;

    localparam host_t HOST_RST = '{sh: TIME_RST, ctrl: 8'h00, stop: 1'b1,
                                   cent_en: 1'b0, ftest: 1'b0};

    host_t q, d;

    logic             in_win;
    logic [OFF_W-1:0] off;
    logic             hw, adv, frz, load, cent_wr;
    rtc_time_t        live_q, live_d, shadow_q;

    assign in_win   = &addr[ADDR_W-1:OFF_W];
    assign off      = addr[OFF_W-1:0];
    assign hw       = wr_en && in_win;
    assign adv      = tick_1hz && !q.stop;
    assign frz      = q.ctrl[CTRL_FREEZE_BIT] || q.ctrl[CTRL_LOAD_BIT];
    assign load     = hw && (off == OFF_CTRL) && q.ctrl[CTRL_LOAD_BIT] && !wdata[CTRL_LOAD_BIT];
    assign cent_wr  = hw && (off == OFF_DAY);
    assign shadow_q = q.sh;

    rtc_time_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .load     (load),
        .load_val (q.sh),
        .cent_wr  (cent_wr),
        .cent_val (wdata[4]),
        .cent_en  (q.cent_en),
        .live_q   (live_q),
        .live_d   (live_d)
    );

    always_comb begin
        d = q;
        if (hw) begin
            case (off)
                OFF_CTRL: d.ctrl = wdata;
                OFF_SEC: begin
                    d.stop    = wdata[7];
                    d.sh.secs = wdata & MASK_SEC;
                end
                OFF_MIN: d.sh.mins = wdata & MASK_MIN;
                OFF_HR:  d.sh.hrs  = wdata & MASK_HR;
                OFF_DAY: begin
                    d.ftest   = wdata[6];
                    d.cent_en = wdata[5];
                    d.sh.cent = wdata[4];
                    d.sh.dow  = wdata[2:0];
                end
                OFF_DATE: d.sh.date = wdata & MASK_DATE;
                OFF_MON:  d.sh.mon  = wdata & MASK_MON;
                default:  d.sh.yr   = wdata;
            endcase
        end
        // refresh from the counters' next state so the copy is coherent
        if (adv && !frz) d.sh = live_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= HOST_RST;
        else        q <= d;
    end

    rtc_read_mux u_rd (
        .hit     (in_win),
        .off     (off),
        .shadow  (q.sh),
        .ctrl    (q.ctrl),
        .stop    (q.stop),
        .cent_en (q.cent_en),
        .ftest   (q.ftest),
        .rdata   (rdata)
    );
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1hz,
    input logic              stop,
    input logic              frz,
    input logic              hw,
    input logic              load,
    input logic              cent_wr,
    input rtc_time_t         live_q,
    input rtc_time_t         shadow_q,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata
);
    logic mon_sel, day_sel;
    assign mon_sel = (&addr[ADDR_W-1:OFF_W]) && (addr[OFF_W-1:0] == OFF_MON);
    assign day_sel = (&addr[ADDR_W-1:OFF_W]) && (addr[OFF_W-1:0] == OFF_DAY);

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !load && !cent_wr) |=> $stable(live_q));

    // R13
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !load && !cent_wr) |=> $stable(live_q));

    // R8
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frz && !hw) |=> $stable(shadow_q));

    // R9
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (live_q == $past(shadow_q)));

    // R11
    refresh_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !stop && !frz) |=> (shadow_q == live_q));

    // R12
    mon_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mon_sel |-> (rdata[7:5] == 3'b000));

    // R12
    day_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        day_sel |-> (rdata[7] == 1'b0 && rdata[3] == 1'b0));
endmodule

bind bcd_rtc rtc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .stop     (q.stop),
    .frz      (frz),
    .hw       (hw),
    .load     (load),
    .cent_wr  (cent_wr),
    .live_q   (live_q),
    .shadow_q (shadow_q),
    .addr     (addr),
    .rdata    (rdata)
);

// File: tb/tb_bcd_rtc.sv
module tb_bcd_rtc;
    localparam int AW   = 15;
    localparam int BASE = (1 << AW) - 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_1hz = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rdata;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // behavioural model: live in binary, shadow as raw bytes
    int lv[7];
    int sv[7];
    int lcb, scb, ctrl, stop, ceb, ft;

    always #4 clk = ~clk;

    bcd_rtc #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
        .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
    );

    function automatic int to_bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int from_bcd(input int b);
        return ((b >> 4) & 15) * 10 + (b & 15);
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic m_reset();
        lv = '{0, 0, 0, 1, 1, 1, 0};
        sv = '{0, 0, 0, 1, 1, 1, 0};
        lcb = 0; scb = 0; ctrl = 0; stop = 1; ceb = 0; ft = 0;
    endtask

    task automatic m_tick_live();
        lv[0]++;
        if (lv[0] == 60) begin
            lv[0] = 0; lv[1]++;
            if (lv[1] == 60) begin
                lv[1] = 0; lv[2]++;
                if (lv[2] == 24) begin
                    lv[2] = 0;
                    lv[3] = lv[3] % 7 + 1;
                    lv[4]++;
                    if (lv[4] > mdays(lv[5], lv[6])) begin
                        lv[4] = 1; lv[5]++;
                        if (lv[5] > 12) begin
                            lv[5] = 1; lv[6]++;
                            if (lv[6] == 100) begin
                                lv[6] = 0;
                                if (ceb != 0) lcb = 1 - lcb;
                            end
                        end
                    end
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reset();
        end else begin
            bit hw, adv, frz, ld;
            int o, wd;
            hw  = wr_en && (int'(addr) >= BASE);
            o   = int'(addr) - BASE;
            wd  = int'(wdata);
            adv = tick_1hz && (stop == 0);
            frz = ((ctrl >> 6) & 3) != 0;
            ld  = hw && o == 0 && ((ctrl >> 7) & 1) == 1 && ((wd >> 7) & 1) == 0;
            if (ld) begin
                for (int i = 0; i < 7; i++) lv[i] = from_bcd(sv[i]);
                lcb = scb;
            end else begin
                if (adv) m_tick_live();
                if (hw && o == 4) lcb = (wd >> 4) & 1;
            end
            if (hw) begin
                case (o)
                    0: ctrl = wd;
                    1: begin stop = (wd >> 7) & 1; sv[0] = wd & 'h7F; end
                    2: sv[1] = wd & 'h7F;
                    3: sv[2] = wd & 'h3F;
                    4: begin ft = (wd >> 6) & 1; ceb = (wd >> 5) & 1;
                             scb = (wd >> 4) & 1; sv[3] = wd & 7; end
                    5: sv[4] = wd & 'h3F;
                    6: sv[5] = wd & 'h1F;
                    default: sv[6] = wd;
                endcase
            end
            if (adv && !frz) begin
                for (int i = 0; i < 7; i++) sv[i] = to_bcd(lv[i]);
                scb = lcb;
            end
        end
    end

    function automatic logic [7:0] exp_read(input logic [AW-1:0] a);
        int o;
        if (int'(a) < BASE) return 8'h00;
        o = int'(a) - BASE;
        case (o)
            0: return 8'(ctrl);
            1: return 8'((stop << 7) | sv[0]);
            4: return 8'((ft << 6) | (ceb << 5) | (scb << 4) | sv[3]);
            default: return 8'(sv[o - 1]);
        endcase
    endfunction

    // one cycle: drive at negedge, compare the model just after
    task automatic cyc(input logic [AW-1:0] a, input logic we, input logic [7:0] dv, input logic tk);
        logic [7:0] e;
        @(negedge clk);
        addr = a; wr_en = we; wdata = dv; tick_1hz = tk;
        #1;
        e = exp_read(a);
        total++;
        if (rdata !== e) begin
            bad++;
            $display("FAIL %s model compare addr=%h got=%h exp=%h", cur_req, a, rdata, e);
        end
    endtask

    task automatic wr(input int o, input logic [7:0] dv);
        cyc(AW'(BASE + o), 1'b1, dv, 1'b0);
    endtask

    task automatic tick();
        cyc(AW'(BASE + 1), 1'b0, 8'h00, 1'b1);
        cyc(AW'(BASE + 1), 1'b0, 8'h00, 1'b0);
    endtask

    task automatic expect_reg(input int o, input logic [7:0] v, input string req);
        cyc(AW'(BASE + o), 1'b0, 8'h00, 1'b0);
        total++;
        if (rdata !== v) begin
            bad++;
            $display("FAIL %s offset %0d got=%h exp=%h", req, o, rdata, v);
        end
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                            input logic [7:0] dy, input logic [7:0] dt, input logic [7:0] mo,
                            input logic [7:0] y);
        wr(0, 8'h80);
        wr(1, s); wr(2, mi); wr(3, h); wr(4, dy); wr(5, dt); wr(6, mo); wr(7, y);
        wr(0, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        cur_req = "R1";
        expect_reg(0, 8'h00, "R1"); expect_reg(1, 8'h80, "R1");
        expect_reg(2, 8'h00, "R1"); expect_reg(3, 8'h00, "R1");
        expect_reg(4, 8'h01, "R1"); expect_reg(5, 8'h01, "R1");
        expect_reg(6, 8'h01, "R1"); expect_reg(7, 8'h00, "R1");

        // R7 stopped at reset
        cur_req = "R7";
        tick(); tick();
        expect_reg(1, 8'h80, "R7");
        wr(1, 8'h00);
        tick(); tick(); tick();
        expect_reg(1, 8'h03, "R7");

        // R2 outside the window
        cur_req = "R2";
        cyc(AW'(16'h0100), 1'b1, 8'h55, 1'b0);
        cyc(AW'(16'h0100), 1'b0, 8'h00, 1'b0);
        total++;
        if (rdata !== 8'h00) begin
            bad++; $display("FAIL R2 outside read got=%h exp=00", rdata);
        end
        expect_reg(1, 8'h03, "R2");

        // R3 R4 R5: 31-day month end, day-of-week 7 -> 1
        cur_req = "R3";
        set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h01, 8'h23);
        tick();
        expect_reg(1, 8'h59, "R3");
        tick();
        expect_reg(1, 8'h00, "R3"); expect_reg(2, 8'h00, "R3"); expect_reg(3, 8'h00, "R3");
        expect_reg(4, 8'h01, "R5"); expect_reg(5, 8'h01, "R4"); expect_reg(6, 8'h02, "R4");

        cur_req = "R4";
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
        tick();
        expect_reg(5, 8'h01, "R4"); expect_reg(6, 8'h03, "R4"); expect_reg(4, 8'h04, "R5");
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        tick();
        expect_reg(5, 8'h29, "R4"); expect_reg(6, 8'h02, "R4");
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
        tick();
        expect_reg(5, 8'h01, "R4"); expect_reg(6, 8'h03, "R4");
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h00);
        tick();
        expect_reg(5, 8'h29, "R4");
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h23);
        tick();
        expect_reg(5, 8'h01, "R4"); expect_reg(6, 8'h05, "R4");
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h05, 8'h23);
        tick();
        expect_reg(5, 8'h31, "R4"); expect_reg(6, 8'h05, "R4");

        // R6 year wrap with and without century enable
        cur_req = "R6";
        set_time(8'h59, 8'h59, 8'h23, 8'h21, 8'h31, 8'h12, 8'h99);
        tick();
        expect_reg(7, 8'h00, "R6"); expect_reg(6, 8'h01, "R6"); expect_reg(4, 8'h32, "R6");
        set_time(8'h59, 8'h59, 8'h23, 8'h11, 8'h31, 8'h12, 8'h99);
        tick();
        expect_reg(7, 8'h00, "R6"); expect_reg(4, 8'h12, "R6");

        // R9 load handshake
        cur_req = "R9";
        wr(0, 8'h80); wr(1, 8'h30);
        tick();
        expect_reg(1, 8'h30, "R9");
        wr(2, 8'h10); wr(0, 8'h00);
        expect_reg(1, 8'h30, "R9");
        tick();
        expect_reg(1, 8'h31, "R9"); expect_reg(2, 8'h10, "R9");

        // R8 freeze
        cur_req = "R8";
        wr(0, 8'h40);
        for (int i = 0; i < 5; i++) tick();
        expect_reg(1, 8'h31, "R8");
        wr(0, 8'h00);
        expect_reg(1, 8'h31, "R8");
        tick();
        expect_reg(1, 8'h37, "R8");

        // R10 tick together with freeze request
        cur_req = "R10";
        cyc(AW'(BASE), 1'b1, 8'h40, 1'b1);
        expect_reg(1, 8'h38, "R10");
        tick();
        expect_reg(1, 8'h38, "R10");
        wr(0, 8'h00);

        // R11 shadow-only writes and direct stop bit
        cur_req = "R11";
        wr(2, 8'h45);
        expect_reg(2, 8'h45, "R11");
        tick();
        expect_reg(2, 8'h10, "R11"); expect_reg(1, 8'h40, "R11");
        wr(1, 8'h80);
        tick();
        expect_reg(1, 8'h80, "R11");
        wr(1, 8'h00);
        tick();
        expect_reg(1, 8'h41, "R11");

        // R12 masked bits
        cur_req = "R12";
        wr(3, 8'hFF); expect_reg(3, 8'h3F, "R12");
        wr(6, 8'hFF); expect_reg(6, 8'h1F, "R12");
        wr(4, 8'h88); expect_reg(4, 8'h00, "R12");
        tick();
        expect_reg(3, 8'h00, "R12"); expect_reg(6, 8'h01, "R12"); expect_reg(4, 8'h02, "R12");

        // R13 no tick, no change
        cur_req = "R13";
        for (int i = 0; i < 20; i++) cyc(AW'(BASE + 1), 1'b0, 8'h00, 1'b0);
        expect_reg(1, 8'h42, "R13");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule